// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide asynchronous static RAM. Testbenches of SRAM controllers use it as their target. On every rising clock edge it samples the active-low control pins: chip select, write enable, output enable, and one select for each byte lane. It turns them into one of four cycle modes and then performs a whole-word or single-byte access, or no access at all. With `ADDR_W` set to 17 it models the full 131,072-word array. The default is smaller so that elaboration stays light.

The shared bidirectional data bus is not modelled as a tristate net. It is split into a write-data input, a registered read-data output, and one drive flag per byte lane. Lane 0 carries bits 7:0 and is gated by the lower select. Lane 1 carries bits 15:8 and is gated by the upper select. A controller bench resolves the bus from these signals. A violation flag reports an address change in the middle of a write window, when chip select and write enable are both held low.

Top module: `sram_model`

## Requirements
- R1: While `rstN` is low, `laneDrive` is 2'b00, `cycleMode` is 2'b00 and `violation` is 0. Reset does not initialise the storage, and words never written read back as unknown.
- R2: On an edge where `csN` is high, the next `cycleMode` is 2'b00 (unselected) and `laneDrive` is 2'b00. No byte is written, whatever the other pins are doing.
- R3: On an edge where `csN` is low but both `lbN` and `ubN` are high, the block is also unselected: `cycleMode` becomes 2'b00, `laneDrive` becomes 2'b00, and no byte is written.
- R4: On an edge where `csN` is low, `weN` is high, `oeN` is high and at least one byte select is low, `cycleMode` becomes 2'b01 (output disable) and `laneDrive` becomes 2'b00.
- R5: On an edge where `csN` is low, `weN` is high, `oeN` is low and at least one byte select is low, `cycleMode` becomes 2'b10 (read). Each lane whose select is low sets its `laneDrive` bit and loads its byte of the word at `addr` into `dataOut`. Bit 0 and bits 7:0 belong to `lbN`, and bit 1 and bits 15:8 belong to `ubN`. A lane whose select is high keeps `laneDrive` at 0.
- R6: On an edge where `csN` and `weN` are low, `cycleMode` becomes 2'b11 (write). Each lane whose select is low stores its byte of `dataIn` at `addr`, and the other lane's stored byte is unchanged. The level of `oeN` has no effect.
- R7: After any edge where `weN` is low, `laneDrive` is 2'b00, even when `oeN` is low.
- R8: `violation` is high for the cycle after an edge at which `csN` and `weN` were low both at that edge and at the edge before, and `addr` differed between those two edges. Otherwise it is low.
- R9: The store holds 2^`ADDR_W` distinct words. Each address keeps its own value, independent of every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| lbN | input | 1 | Lower byte select (bits 7:0), active low |
| ubN | input | 1 | Upper byte select (bits 15:8), active low |
| dataIn | input | 2*LANE_W | Write data |
| dataOut | output | 2*LANE_W | Registered read data |
| laneDrive | output | 2 | Per-lane drive flag; 0 means that lane is high impedance |
| cycleMode | output | 2 | Decoded mode: 00 unselected, 01 output disable, 10 read, 11 write |
| violation | output | 1 | Address moved inside a write window |

## Verification
The bench builds the model with `ADDR_W` = 6 and `LANE_W` = 8. At that size it can fill every one of the 64 words with an address-derived pattern and read all of them back, which proves that no two addresses alias. The 8-bit lanes keep the byte-merge cases readable: upper-only and lower-only writes over a full word, and single-lane reads. The same settings let the bench step through each row of the mode decode and through the write-window address-change cases within a few hundred cycles.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_READ  = 2'b10,
    MODE_WRITE = 2'b11
  } cycle_mode_e;

  typedef struct packed {
    cycle_mode_e      mode;
    logic [LANES-1:0] laneWr;
    logic [LANES-1:0] laneRd;
  } lane_strobe_t;
endpackage

// File: rtl/sram_model_ctrl.sv
module sram_model_ctrl
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    csN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [LANES-1:0]        selN,
  output lane_strobe_t            strobe,
  output cycle_mode_e             modeQ,
  output logic                    violation
);
  logic              anySel;
  logic              selected;
  logic              winNow;
  logic              prevWin;
  logic [ADDR_W-1:0] prevAddr;

  // A cycle counts as selected only with chip select low and some lane picked.
  assign anySel   = ~&selN;
  assign selected = !csN && anySel;
  assign winNow   = !csN && !weN;

  always_comb begin
    strobe = '0;
    strobe.mode = MODE_IDLE;
    if (selected) begin
      if (!weN) begin
        strobe.mode   = MODE_WRITE;
        strobe.laneWr = ~selN;
      end else if (oeN) begin
        strobe.mode   = MODE_HOLD;
      end else begin
        strobe.mode   = MODE_READ;
        strobe.laneRd = ~selN;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_IDLE;
      prevWin   <= 1'b0;
      prevAddr  <= '0;
      violation <= 1'b0;
    end else begin
      modeQ     <= strobe.mode;
      prevWin   <= winNow;
      prevAddr  <= addr;
      violation <= winNow && prevWin && (addr != prevAddr);
    end
  end
endmodule

// File: rtl/sram_model_lane.sv
module sram_model_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [LANE_W-1:0] wrData,
  output logic [LANE_W-1:0] rdData,
  output logic              drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];

  // Storage carries no reset: its contents start unknown.
  always_ff @(posedge clk) begin
    if (wrEn) store[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rdEn) rdData <= store[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drive <= 1'b0;
    else       drive <= rdEn;
  end
endmodule

// File: rtl/sram_model.sv
module sram_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    csN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic                    lbN,
  input  logic                    ubN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic [LANES-1:0]        laneDrive,
  output logic [1:0]              cycleMode,
  output logic                    violation
);
  lane_strobe_t strobe;
  cycle_mode_e  modeQ;

  sram_model_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .csN       (csN),
    .weN       (weN),
    .oeN       (oeN),
    .selN      ({ubN, lbN}),
    .strobe    (strobe),
    .modeQ     (modeQ),
    .violation (violation)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_model_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
      .clk    (clk),
      .rstN   (rstN),
      .addr   (addr),
      .wrEn   (strobe.laneWr[g]),
      .rdEn   (strobe.laneRd[g]),
      .wrData (dataIn[g*LANE_W +: LANE_W]),
      .rdData (dataOut[g*LANE_W +: LANE_W]),
      .drive  (laneDrive[g])
    );
  end

  assign cycleMode = modeQ;
endmodule

// File: rtl/sram_model_chk.sv
module sram_model_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              csN,
  input logic              weN,
  input logic              oeN,
  input logic              lbN,
  input logic              ubN,
  input logic [1:0]        laneDrive,
  input logic [1:0]        cycleMode,
  input logic              violation
);
  a_r2_unselected_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (laneDrive == 2'b00 && cycleMode == 2'b00));

  a_r3_no_lane_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && lbN && ubN) |=> (laneDrive == 2'b00 && cycleMode == 2'b00));

  a_r4_output_off: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && oeN && !(lbN && ubN)) |=> (laneDrive == 2'b00 && cycleMode == 2'b01));

  a_r5_read_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !oeN && !(lbN && ubN)) |=>
      (cycleMode == 2'b10 && laneDrive == ~$past({ubN, lbN})));

  a_r7_write_hiz: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> (laneDrive == 2'b00));

  a_r8_violation_cause: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> ($past(!csN && !weN) && ($past(addr) != $past(addr, 2))));
endmodule

bind sram_model sram_model_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .csN       (csN),
  .weN       (weN),
  .oeN       (oeN),
  .lbN       (lbN),
  .ubN       (ubN),
  .laneDrive (laneDrive),
  .cycleMode (cycleMode),
  .violation (violation)
);

// File: tb/sram_model_test.sv
module sram_model_test;
  localparam int ADDR_W = 6;
  localparam int LANE_W = 8;
  localparam int DW     = 2 * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              csN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [DW-1:0]     dataIn = '0;
  logic [DW-1:0]     dataOut;
  logic [1:0]        laneDrive;
  logic [1:0]        cycleMode;
  logic              violation;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_model #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .dataIn(dataIn), .dataOut(dataOut),
    .laneDrive(laneDrive), .cycleMode(cycleMode), .violation(violation)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply pins after a falling edge; outputs are looked at on the next falling edge.
  task automatic step(input logic c, input logic w, input logic o, input logic l, input logic u,
                      input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    csN = c; weN = w; oeN = o; lbN = l; ubN = u; addr = a; dataIn = d;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic writeWord(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    step(0, 0, 1, 0, 0, a, d);
    idle();
  endtask

  task automatic readWord(input logic [ADDR_W-1:0] a, input string req, input logic [DW-1:0] exp);
    step(0, 1, 0, 0, 0, a, '0);
    check({req, " data"}, dataOut, exp);
    check({req, " drive"}, {14'd0, laneDrive}, 16'd3);
  endtask

  task automatic t_reset();
    check("R1 drive", {14'd0, laneDrive}, 16'd0);
    check("R1 mode", {14'd0, cycleMode}, 16'd0);
    check("R1 violation", {15'd0, violation}, 16'd0);
    rstN = 1'b1;
    idle();
    step(0, 1, 0, 0, 0, 6'd9, '0);
    check("R1 unwritten reads unknown", dataOut, 16'hxxxx);
    idle();
  endtask

  task automatic t_modes();
    writeWord(6'd3, 16'h1234);
    step(1, 0, 0, 0, 0, 6'd3, 16'hFFFF);
    check("R2 mode", {14'd0, cycleMode}, 16'd0);
    check("R2 drive", {14'd0, laneDrive}, 16'd0);
    step(0, 0, 0, 1, 1, 6'd3, 16'hEEEE);
    check("R3 mode", {14'd0, cycleMode}, 16'd0);
    check("R3 drive", {14'd0, laneDrive}, 16'd0);
    idle();
    readWord(6'd3, "R2 R3 write ignored", 16'h1234);
    step(0, 1, 1, 0, 0, 6'd3, '0);
    check("R4 mode", {14'd0, cycleMode}, 16'd1);
    check("R4 drive", {14'd0, laneDrive}, 16'd0);
    idle();
  endtask

  task automatic t_lanes();
    writeWord(6'd10, 16'hA5C3);
    step(0, 1, 0, 0, 1, 6'd10, '0);
    check("R5 lower drive", {14'd0, laneDrive}, 16'd1);
    check("R5 lower mode", {14'd0, cycleMode}, 16'd2);
    check("R5 lower data", {8'd0, dataOut[7:0]}, 16'h00C3);
    step(0, 1, 0, 1, 0, 6'd10, '0);
    check("R5 upper drive", {14'd0, laneDrive}, 16'd2);
    check("R5 upper data", {8'd0, dataOut[15:8]}, 16'h00A5);
    step(0, 0, 1, 1, 0, 6'd10, 16'h7E11);
    check("R6 mode", {14'd0, cycleMode}, 16'd3);
    idle();
    readWord(6'd10, "R6 upper merge", 16'h7EC3);
    step(0, 0, 0, 0, 1, 6'd10, 16'h2299);
    check("R7 drive with oe low", {14'd0, laneDrive}, 16'd0);
    check("R6 mode oe low", {14'd0, cycleMode}, 16'd3);
    idle();
    readWord(6'd10, "R6 lower merge", 16'h7E99);
  endtask

  task automatic t_violation();
    step(0, 0, 1, 0, 0, 6'd20, 16'h0001);
    check("R8 first cycle", {15'd0, violation}, 16'd0);
    step(0, 0, 1, 0, 0, 6'd21, 16'h0002);
    check("R8 moved address", {15'd0, violation}, 16'd1);
    step(0, 0, 1, 0, 0, 6'd21, 16'h0003);
    check("R8 steady address", {15'd0, violation}, 16'd0);
    step(1, 0, 1, 0, 0, 6'd22, 16'h0004);
    check("R8 cs high", {15'd0, violation}, 16'd0);
    step(0, 0, 1, 0, 0, 6'd23, 16'h0005);
    check("R8 window reopened", {15'd0, violation}, 16'd0);
    idle();
    check("R8 after idle", {15'd0, violation}, 16'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, i[ADDR_W-1:0], {i[7:0] ^ 8'h5A, i[7:0]});
    idle();
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 0, 0, 0, i[ADDR_W-1:0], '0);
      check("R9 word", dataOut, {i[7:0] ^ 8'h5A, i[7:0]});
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_lanes();
    t_violation();
    t_full();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule